// File: doc/BRIEF.md
# Dual-Port Burst-of-Two DDR SRAM

This block is a synthesizable behavioural model of a quad-data-rate style static memory. It has one read port and one write port. Each is opened by its own active-low select, and both share a single address bus and a complementary clock pair `k` / `k_n`. Every accepted command moves a burst of two words. The first word sits at the supplied address. The second sits at the same address with its lowest bit inverted, so a burst stays inside its aligned pair.

Write data arrives on both clock edges. The first beat is taken at the `k` rising edge that accepts the command, and the second at the `k_n` rising edge that follows. Each beat carries its own active-low lane enables. Read data leaves through a short pipeline that presents one beat per half-cycle, with a `qvalid` strobe that doubles as the pad output enable. A read and a write may start in the same cycle, and either port may issue a command on every cycle.

The intended use is as a fast-simulating stand-in for an external burst memory in a larger chip environment. It can also serve as a small on-chip buffer that needs simultaneous read and write bandwidth.

Top module: `sram_b2_ddr`

## Requirements
- R1: While `rst` is high, `qvalid` is low and `q` is all zeros, and no read beat is pending once `rst` falls.
- R2: When `wps_n` is low at a `k` rising edge, `d` and `bws_n` sampled at that edge are written to address A (`addr`), and `d` and `bws_n` sampled at the next `k_n` rising edge are written to address A with bit 0 inverted.
- R3: When `rps_n` is low at `k` rising edge number c, the word at A appears on `q` from the `k_n` rising edge after edge c+1 until edge c+2 (while `k` is low). The word at A with bit 0 inverted appears from edge c+2 until the next `k_n` rising edge (while `k` is high).
- R4: The second word of every burst, read or write, uses the supplied address with only bit 0 inverted, so an odd base address wraps down to its even partner.
- R5: `bws_n[i]` low writes bits `[i*LW +: LW]` of its beat, where LW = DATA_W / number of lanes. There are 2 lanes for DATA_W = 8 (nibbles) and DATA_W/9 lanes otherwise. A lane whose enable is high keeps its previous content.
- R6: Whenever no read beat is being presented, including the half-cycle right after the last beat, `qvalid` is low and `q` is all zeros, which marks the pads as released.
- R7: `qvalid` is high for exactly the two half-cycles of each read burst. Reads issued on consecutive cycles give an unbroken stream of beats.
- R8: A read and a write accepted at the same `k` rising edge both proceed, and the read returns the newly written words with the lane enables applied.
- R9: The selects are sampled only at `k` rising edges. A select that is low only around a `k_n` rising edge starts no read and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Positive clock; commands, address and first write beat are sampled on its rising edge |
| k_n | input | 1 | Complementary clock; second write beat is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset, seen by both clock phases |
| rps_n | input | 1 | Active-low read port select |
| wps_n | input | 1 | Active-low write port select |
| addr | input | ADDR_W | Shared burst base address |
| d | input | DATA_W | Write data, one beat per clock edge |
| bws_n | input | NBW | Active-low lane write enables for the current beat |
| q | output | DATA_W | Read data, one beat per half-cycle; zero when released |
| qvalid | output | 1 | High while a read beat is presented; output enable for the pads |

## Verification
Every address is first filled through even-based bursts and read back from both even and odd bases. This separates the base word from its partner and shows that odd bases wrap to the even neighbour rather than incrementing. A second fill with odd bases, read from even bases, checks the same wrap on the write side. A sweep over all sixteen pairs of two-lane enables across both beats tells which beat's mask landed on which lane. Same-cycle read-and-write bursts show that new data is returned. Gapped and back-to-back read trains check that the strobe neither drops between chained bursts nor lingers after the last beat. Selects pulsed only around the falling half of `k` must leave both the output and the array untouched.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

    // Number of lane enables for a given data width: nibble lanes on the
    // narrow variant, nine-bit lanes on the wider ones.
    function automatic int bw_count(input int dw);
        if (dw == 8) begin
            return 2;
        end
        return (dw + 8) / 9;
    endfunction

    function automatic int lane_width(input int dw);
        return dw / bw_count(dw);
    endfunction

    // Which half of the K period is currently driving the output pins.
    typedef enum logic {
        PH_LOW_HALF  = 1'b0,   // after K# rise: first beat of a burst
        PH_HIGH_HALF = 1'b1    // after K rise: second beat of a burst
    } half_e;

endpackage

// File: rtl/sram_b2_cmd.sv
module sram_b2_cmd #(
    parameter int AW  = 8,
    parameter int DW  = 18,
    parameter int NBW = 2
) (
    input  logic           k,
    input  logic           rst,
    input  logic           rps_n,
    input  logic           wps_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  d,
    input  logic [NBW-1:0] bws_n,
    output logic           rd_go,
    output logic           wr_go,
    output logic [AW-1:0]  cmd_a,
    output logic [DW-1:0]  d0_q,
    output logic [NBW-1:0] m0_q
);

    typedef struct packed {
        logic           rd;
        logic           wr;
        logic [AW-1:0]  a;
        logic [DW-1:0]  d0;
        logic [NBW-1:0] m0;
    } cmd_t;

    cmd_t cmd_nxt;
    cmd_t cmd_q;

    always_comb begin
        cmd_nxt.rd = ~rps_n;
        cmd_nxt.wr = ~wps_n;
        cmd_nxt.a  = addr;
        cmd_nxt.d0 = d;
        cmd_nxt.m0 = bws_n;
    end

    // Only the K rising edge looks at the selects.
    always_ff @(posedge k) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_nxt;
        end
    end

    assign rd_go = cmd_q.rd;
    assign wr_go = cmd_q.wr;
    assign cmd_a = cmd_q.a;
    assign d0_q  = cmd_q.d0;
    assign m0_q  = cmd_q.m0;

endmodule

// File: rtl/sram_b2_array.sv
module sram_b2_array
    import sram_b2_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 18,
    parameter int NBW = 2
) (
    input  logic           k_n,
    input  logic           wr_go,
    input  logic [AW-1:0]  cmd_a,
    input  logic [DW-1:0]  d0_q,
    input  logic [NBW-1:0] m0_q,
    input  logic [DW-1:0]  d,
    input  logic [NBW-1:0] bws_n,
    output logic [DW-1:0]  rdata0,
    output logic [DW-1:0]  rdata1
);

    localparam int DEPTH = 1 << AW;
    localparam int LW    = lane_width(DW);

    logic [DW-1:0] mem [DEPTH];

    logic [AW-1:0] a_base;
    logic [AW-1:0] a_pair;
    logic [DW-1:0] cur0;
    logic [DW-1:0] cur1;
    logic [DW-1:0] nxt0;
    logic [DW-1:0] nxt1;

    assign a_base = cmd_a;
    assign a_pair = {cmd_a[AW-1:1], ~cmd_a[0]};

    assign cur0 = mem[a_base];
    assign cur1 = mem[a_pair];

    // Lane merge: enable low takes the new beat, high keeps stored data.
    for (genvar i = 0; i < NBW; i++) begin : g_lane
        assign nxt0[i*LW +: LW] = m0_q[i]  ? cur0[i*LW +: LW] : d0_q[i*LW +: LW];
        assign nxt1[i*LW +: LW] = bws_n[i] ? cur1[i*LW +: LW] : d[i*LW +: LW];
    end

    // Both words of a burst commit at the K# rise that brings beat one.
    always_ff @(posedge k_n) begin
        if (wr_go) begin
            mem[a_base] <= nxt0;
            mem[a_pair] <= nxt1;
        end
    end

    assign rdata0 = cur0;
    assign rdata1 = cur1;

endmodule

// File: rtl/sram_b2_rdpipe.sv
module sram_b2_rdpipe
    import sram_b2_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          k,
    input  logic          k_n,
    input  logic          rst,
    input  logic          rd_go,
    input  logic [DW-1:0] rdata0,
    input  logic [DW-1:0] rdata1,
    output logic [DW-1:0] q,
    output logic          qvalid,
    output logic          even_v,
    output logic          odd_v
);

    typedef struct packed {
        logic          v;
        logic [DW-1:0] w0;
        logic [DW-1:0] w1;
    } fetch_t;

    typedef struct packed {
        logic          v;
        logic [DW-1:0] w;
    } beat_t;

    fetch_t fetch_q;
    beat_t  lo_q;
    beat_t  hi_q;
    beat_t  sel;
    half_e  ph;

    // Array access one K cycle after the command; writes of the same
    // command have committed at the K# rise in between.
    always_ff @(posedge k) begin
        if (rst) begin
            fetch_q <= '0;
            hi_q    <= '0;
        end else begin
            fetch_q.v  <= rd_go;
            fetch_q.w0 <= rdata0;
            fetch_q.w1 <= rdata1;
            hi_q.v     <= fetch_q.v;
            hi_q.w     <= fetch_q.w1;
        end
    end

    always_ff @(posedge k_n) begin
        if (rst) begin
            lo_q <= '0;
        end else begin
            lo_q.v <= fetch_q.v;
            lo_q.w <= fetch_q.w0;
        end
    end

    assign ph = k ? PH_HIGH_HALF : PH_LOW_HALF;

    always_comb begin
        case (ph)
            PH_HIGH_HALF: sel = hi_q;
            default:      sel = lo_q;
        endcase
    end

    assign qvalid = sel.v;
    assign q      = sel.v ? sel.w : '0;
    assign even_v = lo_q.v;
    assign odd_v  = hi_q.v;

endmodule

// File: rtl/sram_b2_ddr.sv
module sram_b2_ddr
    import sram_b2_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 18,
    localparam int NBW    = bw_count(DATA_W)
) (
    input  logic              k,
    input  logic              k_n,
    input  logic              rst,
    input  logic              rps_n,
    input  logic              wps_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d,
    input  logic [NBW-1:0]    bws_n,
    output logic [DATA_W-1:0] q,
    output logic              qvalid
);

    logic              rd_go;
    logic              wr_go;
    logic [ADDR_W-1:0] cmd_a;
    logic [DATA_W-1:0] d0_q;
    logic [NBW-1:0]    m0_q;
    logic [DATA_W-1:0] rdata0;
    logic [DATA_W-1:0] rdata1;
    logic              even_v;
    logic              odd_v;

    sram_b2_cmd #(
        .AW (ADDR_W),
        .DW (DATA_W),
        .NBW(NBW)
    ) u_cmd (
        .k    (k),
        .rst  (rst),
        .rps_n(rps_n),
        .wps_n(wps_n),
        .addr (addr),
        .d    (d),
        .bws_n(bws_n),
        .rd_go(rd_go),
        .wr_go(wr_go),
        .cmd_a(cmd_a),
        .d0_q (d0_q),
        .m0_q (m0_q)
    );

    sram_b2_array #(
        .AW (ADDR_W),
        .DW (DATA_W),
        .NBW(NBW)
    ) u_array (
        .k_n   (k_n),
        .wr_go (wr_go),
        .cmd_a (cmd_a),
        .d0_q  (d0_q),
        .m0_q  (m0_q),
        .d     (d),
        .bws_n (bws_n),
        .rdata0(rdata0),
        .rdata1(rdata1)
    );

    sram_b2_rdpipe #(
        .DW(DATA_W)
    ) u_rd (
        .k     (k),
        .k_n   (k_n),
        .rst   (rst),
        .rd_go (rd_go),
        .rdata0(rdata0),
        .rdata1(rdata1),
        .q     (q),
        .qvalid(qvalid),
        .even_v(even_v),
        .odd_v (odd_v)
    );

endmodule

// File: rtl/sram_b2_chk.sv
module sram_b2_chk #(
    parameter int DW = 18
) (
    input logic          k,
    input logic          rst,
    input logic          rps_n,
    input logic          wps_n,
    input logic          wr_go,
    input logic          even_v,
    input logic          odd_v,
    input logic          qvalid,
    input logic [DW-1:0] q
);

    AST_RD_BEAT1_LATENCY: assert property (@(posedge k) disable iff (rst) !rps_n |=> ##2 odd_v); // R3

    AST_NO_SPURIOUS_BEAT: assert property (@(posedge k) disable iff (rst) rps_n |=> ##2 !odd_v); // R7

    AST_BEATS_PAIRED: assert property (@(posedge k) disable iff (rst) even_v |=> odd_v); // R7

    AST_WR_ACCEPT: assert property (@(posedge k) disable iff (rst) !wps_n |=> wr_go); // R2

    AST_WR_RISE_ONLY: assert property (@(posedge k) disable iff (rst) wps_n |=> !wr_go); // R9

    AST_RELEASED_IDLE: assert property (@(posedge k) disable iff (rst) !qvalid |-> (q == '0)); // R6

endmodule

bind sram_b2_ddr sram_b2_chk #(
    .DW(DATA_W)
) u_chk (
    .k     (k),
    .rst   (rst),
    .rps_n (rps_n),
    .wps_n (wps_n),
    .wr_go (wr_go),
    .even_v(even_v),
    .odd_v (odd_v),
    .qvalid(qvalid),
    .q     (q)
);

// File: tb/sram_b2_ddr_tb.sv
module sram_b2_ddr_tb;

    localparam int AW = 8;
    localparam int DW = 18;
    localparam int NB = 2;
    localparam int LW = 9;
    localparam int NS = 1024;

    logic          k     = 1'b0;
    logic          rst   = 1'b1;
    logic          rps_n = 1'b1;
    logic          wps_n = 1'b1;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] d     = '0;
    logic [NB-1:0] bws_n = '1;
    wire           k_n;
    wire  [DW-1:0] q;
    wire           qvalid;

    assign k_n = ~k;
    always #10 k = ~k;

    sram_b2_ddr #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .k(k), .k_n(k_n), .rst(rst), .rps_n(rps_n), .wps_n(wps_n),
        .addr(addr), .d(d), .bws_n(bws_n), .q(q), .qvalid(qvalid)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;
    bit reported = 1'b0;

    logic [DW-1:0] model [256];
    bit            hv [NS];
    bit            lv [NS];
    logic [DW-1:0] hd [NS];
    logic [DW-1:0] ld [NS];
    string         ht [NS];
    string         lt [NS];

    always @(posedge k) cyc <= cyc + 1;

    initial begin
        for (int i = 0; i < NS; i++) begin
            hv[i] = 1'b0; lv[i] = 1'b0; hd[i] = '0; ld[i] = '0;
            ht[i] = "R6"; lt[i] = "R6";
        end
    end

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [NB-1:0] m);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < NB; i++) begin
            if (!m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] pat_f(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b, ~b, 2'b10};
    endfunction

    function automatic logic [DW-1:0] pat_g(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {~b, 2'b01, b};
    endfunction

    task automatic check_beat(input bit v, input logic [DW-1:0] e, input string t);
        checks++;
        if (v) begin
            if (!(qvalid === 1'b1 && q === e)) begin
                fails++;
                $display("FAIL %s: qvalid=%b q=%h expected qvalid=1 q=%h at %0t", t, qvalid, q, e, $time);
            end
        end else begin
            if (!(qvalid === 1'b0 && q === '0)) begin
                fails++;
                $display("FAIL %s: qvalid=%b q=%h expected qvalid=0 q=0 at %0t", t, qvalid, q, $time);
            end
        end
    endtask

    // Samples 8 ns after each K rise (second beat) and 8 ns after each
    // K# rise (first beat).
    initial begin
        int idx;
        wait (mon_on);
        forever begin
            @(posedge k);
            #8;
            idx = cyc % NS;
            check_beat(hv[idx], hd[idx], ht[idx]);
            hv[idx] = 1'b0; ht[idx] = "R6";
            #10;
            check_beat(lv[idx], ld[idx], lt[idx]);
            lv[idx] = 1'b0; lt[idx] = "R6";
        end
    end

    // Called 5 ns before a K rise; lasts one period.
    task automatic op(input bit rd, input bit wr, input int a,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [NB-1:0] m0, input logic [NB-1:0] m1,
                      input string t);
        int c;
        int b;
        c = cyc + 1;
        b = a ^ 1;
        if (wr) begin
            model[a] = merge(model[a], d0, m0);
            model[b] = merge(model[b], d1, m1);
        end
        if (rd) begin
            lv[(c+1)%NS] = 1'b1; ld[(c+1)%NS] = model[a]; lt[(c+1)%NS] = t;
            hv[(c+2)%NS] = 1'b1; hd[(c+2)%NS] = model[b]; ht[(c+2)%NS] = t;
        end
        rps_n = ~rd; wps_n = ~wr; addr = AW'(a); d = d0; bws_n = m0;
        #10;
        d = d1; bws_n = m1; rps_n = 1'b1; wps_n = 1'b1;
        #10;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 0, '0, '0, '1, '1, "R6");
    endtask

    // Selects low only around the K# rise: must be ignored.
    task automatic glitch(input bit rd, input int a, input logic [DW-1:0] dv);
        int c;
        c = cyc + 1;
        if (rd) begin
            lt[(c+1)%NS] = "R9"; ht[(c+2)%NS] = "R9";
        end
        addr = AW'(a); d = dv; bws_n = '0;
        #10;
        rps_n = ~rd; wps_n = 1'b0;
        #10;
        rps_n = 1'b1; wps_n = 1'b1;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state in both half-cycles
        repeat (3) @(posedge k);
        #8;  check_beat(1'b0, '0, "R1");
        #10; check_beat(1'b0, '0, "R1");
        @(negedge k); #5;
        rst = 1'b0;
        mon_on = 1'b1;
        idle(2);

        // R2: fill every word through even-based bursts
        for (int p = 0; p < 128; p++)
            op(1'b0, 1'b1, 2*p, pat_f(2*p), pat_f(2*p+1), '0, '0, "R2");
        // R3 / R4: read from every base, even and odd, back to back
        for (int a = 0; a < 256; a++)
            op(1'b1, 1'b0, a, '0, '0, '1, '1, (a % 2 == 1) ? "R4" : "R3");
        idle(2);

        // R4: odd-based writes wrap to the even partner
        for (int p = 0; p < 128; p++)
            op(1'b0, 1'b1, 2*p+1, pat_g(2*p+1), pat_g(2*p), '0, '0, "R4");
        for (int p = 0; p < 128; p++)
            op(1'b1, 1'b0, 2*p, '0, '0, '1, '1, "R4");
        idle(2);

        // R5: every lane-enable pair on both beats
        for (int i = 0; i < 16; i++)
            op(1'b0, 1'b1, 2*i, DW'(18'h15A5A ^ (i * 1299)), DW'(18'h0A5C3 ^ (i * 777)),
               NB'(i), NB'(i >> 2), "R5");
        for (int i = 0; i < 16; i++)
            op(1'b1, 1'b0, 2*i, '0, '0, '1, '1, "R5");
        idle(2);

        // R8: read and write accepted at the same edge
        for (int i = 0; i < 8; i++)
            op(1'b1, 1'b1, 40 + 3*i, DW'(18'h3C0F0 + i), DW'(18'h00FF3 ^ (i << 4)),
               NB'(i), NB'(~i), "R8");
        idle(3);

        // R6 / R7: gapped and chained read trains
        op(1'b1, 1'b0, 5, '0, '0, '1, '1, "R7");
        idle(1);
        op(1'b1, 1'b0, 6, '0, '0, '1, '1, "R7");
        idle(2);
        for (int i = 0; i < 3; i++)
            op(1'b1, 1'b0, 100 + i, '0, '0, '1, '1, "R7");
        idle(3);

        // R9: selects low only around the K# rise
        for (int i = 0; i < 8; i++)
            glitch(i % 2 == 1, 2*i, DW'(18'h2FFFF - i));
        idle(3);
        for (int i = 0; i < 8; i++)
            op(1'b1, 1'b0, 2*i, '0, '0, '1, '1, "R9");
        idle(4);

        done = 1'b1;
        report();
        $finish;
    end

endmodule